// File: doc/BRIEF.md
# VMEbus Slave Front End with Write Posting

This block is the slave side of a VMEbus board that gives other bus masters access to local DRAM. A master raises a strobe and holds its address, size, direction and write data steady until the block answers with either a data acknowledge or a bus error. It then drops the strobe, and the block releases its answer one cycle later. An outside decoder says whether the address modifier of the cycle is acceptable, on a single qualifying input. Behind the block sits a local memory port: a request is held until the memory returns a one-cycle acknowledge, after an arbitrary number of cycles.

A three-bit control register sets the block up. Bit 0 enables the slave. Bit 1 limits it to 8- and 16-bit transfers. Bit 2 turns on write posting. With posting on, a write is stored in a one-entry buffer and acknowledged at once, and the buffer then drains to memory on its own. No new cycle is accepted until that drain has finished, so a later read always sees the posted data.

Top module: `vme_post_slave`

## Requirements
- R1: After reset the control register reads 0, and acknowledge, bus error and memory request are all low.
- R2: With the enable bit (control bit 0) at 0, or with the qualifier input low, a cycle gets neither acknowledge nor bus error, and no memory request is issued.
- R3: Size code 0 is a byte, 1 is a 16-bit word and 2 is a 32-bit longword. Byte lane i covers data bits 8i+7..8i and is selected when the low address bits plus the transfer reach it: the mask (2^bytes - 1) is shifted left by address[1:0]. The word address sent to memory is address[AW-1:2].
- R4: Size code 3, and any transfer that would extend past the end of its longword, gets a bus error with no memory access, whatever the mode.
- R5: With the 16-bit-only bit (control bit 1) set, a longword transfer and a word transfer at an odd address get a bus error with no memory access.
- R6: With control bit 1 clear, an aligned longword and a word at offset 1 (lanes 1 and 2) are accepted.
- R7: With the posting bit (control bit 2) clear, a write is acknowledged only after the memory has acknowledged that write.
- R8: With control bit 2 set, a write is acknowledged while its memory write is still outstanding. The memory write follows later with the same word address, lanes and data.
- R9: While a posted write is outstanding, no new cycle is answered until the posted write has completed in memory.
- R10: A read following a posted write to the same address returns the newly written data.
- R11: Exactly one of acknowledge and bus error is given per cycle. It stays high while the strobe stays high, and it is low in the cycle after the strobe drops.
- R12: Read data carries the memory word on the selected lanes and zero on every other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Writes cfg_din into the control register |
| cfg_din | input | 3 | Control value: bit 0 enable, bit 1 16-bit only, bit 2 posting |
| cfg_q | output | 3 | Current control register |
| bus_strb | input | 1 | Cycle strobe, held until answered |
| bus_write | input | 1 | 1 for a write cycle |
| bus_am_ok | input | 1 | Address modifier accepted |
| bus_addr | input | AW | Byte address |
| bus_size | input | 2 | Transfer size code |
| bus_wdata | input | DW | Write data, lane aligned |
| bus_rdata | output | DW | Read data, lane aligned |
| bus_dtack | output | 1 | Data acknowledge |
| bus_berr | output | 1 | Bus error |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW-2 | Memory word address |
| mem_be | output | DW/8 | Memory byte enables |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |

## Verification
The bench sets the memory latency to several cycles and checks that a posted acknowledge arrives before the write count moves. A design that quietly waits for memory would show no later write. It then issues a read to the posted address straight away: a design without hold-off would either answer before the drain or return stale data. The size and offset grid in both modes hunts for a misplaced lane mask or a missing longword-crossing check, which would show as a wrong lane in read-back or as a memory access where a bus error belongs. Disabled or unqualified cycles are watched for any stray answer or request.

// File: rtl/vps_pkg.sv
// Package: shared constants and types of the slave front end.
// Assumes a 32-bit style lane layout where byte lane i is bits 8i+7..8i.
package vps_pkg;
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;
    localparam logic [1:0] SZ_RSVD = 2'd3;

    localparam int CTL_EN   = 0;
    localparam int CTL_D16  = 1;
    localparam int CTL_POST = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM,
        ST_ACK,
        ST_BERR
    } vps_state_e;
endpackage

// File: rtl/vps_decode.sv
// Module: vps_decode
// Turns size code and low address bits into byte enables and an error flag.
// Assumes NB is a power of two and at least 4 (longword fits a word).
module vps_decode
    import vps_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic [$clog2(NB)-1:0] off,
    input  logic [1:0]            size,
    input  logic                  d16,
    output logic [NB-1:0]         be,
    output logic                  err
);
    localparam int OW = $clog2(NB);

    logic [2*NB-1:0] base;
    logic [2*NB-1:0] wide;
    logic            crosses;
    logic            narrow_bad;
    int              span;

    // Build the unshifted lane mask for the requested size
    always_comb begin
        span = 1 << size;
        for (int i = 0; i < 2*NB; i++) begin
            base[i] = (i < span);
        end
    end

    // Shift into position and flag illegal combinations
    always_comb begin
        wide       = base << off;
        crosses    = |wide[2*NB-1:NB];
        narrow_bad = d16 && ((size == SZ_LONG) || ((size == SZ_WORD) && off[0]));
        be         = wide[NB-1:0];
        err        = (size == SZ_RSVD) || crosses || narrow_bad || (OW < 2 && size == SZ_LONG);
    end
endmodule

// File: rtl/vps_post_buf.sv
// Module: vps_post_buf
// One-entry holding buffer for a posted write; filled on load, emptied on done.
// Assumes load is only raised while the buffer is empty.
module vps_post_buf #(
    parameter int WA = 6,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WA-1:0]   ld_addr,
    input  logic [DW/8-1:0] ld_be,
    input  logic [DW-1:0]   ld_data,
    input  logic            done,
    output logic            valid,
    output logic [WA-1:0]   addr,
    output logic [DW/8-1:0] be,
    output logic [DW-1:0]   data
);
    // Capture the write on load and clear the entry when memory completes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            be    <= '0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            addr  <= ld_addr;
            be    <= ld_be;
            data  <= ld_data;
        end else if (done) begin
            valid <= 1'b0;
        end
    end

    AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) load |-> !valid) else $error("load into full buffer"); // R9
    AST_POST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (valid && !done) |=> (valid && $stable(addr) && $stable(be) && $stable(data))) else $error("posted entry changed"); // R8
endmodule

// File: rtl/vps_mem_port.sv
// Module: vps_mem_port
// Steers the local memory request from the posted buffer or the direct path.
// Assumes each source holds its request steady until its done strobe.
module vps_mem_port #(
    parameter int WA = 6,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            post_valid,
    input  logic [WA-1:0]   post_addr,
    input  logic [DW/8-1:0] post_be,
    input  logic [DW-1:0]   post_data,
    input  logic            dir_req,
    input  logic            dir_we,
    input  logic [WA-1:0]   dir_addr,
    input  logic [DW/8-1:0] dir_be,
    input  logic [DW-1:0]   dir_data,
    output logic            post_done,
    output logic            dir_done,
    output logic            mem_req,
    output logic            mem_we,
    output logic [WA-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack
);
    // Posted buffer has priority; direct path only runs when it is empty
    always_comb begin
        mem_req   = post_valid || dir_req;
        mem_we    = post_valid ? 1'b1      : dir_we;
        mem_addr  = post_valid ? post_addr : dir_addr;
        mem_be    = post_valid ? post_be   : dir_be;
        mem_wdata = post_valid ? post_data : dir_data;
        post_done = post_valid && mem_ack;
        dir_done  = !post_valid && dir_req && mem_ack;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be))) else $error("memory request dropped or changed"); // R3
endmodule

// File: rtl/vme_post_slave.sv
// Module: vme_post_slave
// Bus slave front end to local memory with optional write posting.
// Assumes the master holds all cycle inputs steady while bus_strb is high,
// and the memory gives one mem_ack cycle per held request.
module vme_post_slave
    import vps_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_din,
    output logic [2:0]      cfg_q,
    input  logic            bus_strb,
    input  logic            bus_write,
    input  logic            bus_am_ok,
    input  logic [AW-1:0]   bus_addr,
    input  logic [1:0]      bus_size,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_dtack,
    output logic            bus_berr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-3:0]   mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata
);
    localparam int NB = DW / 8;
    localparam int OW = $clog2(NB);
    localparam int WA = AW - OW;

    vps_state_e    state;
    logic [2:0]    ctl_q;
    logic          go;
    logic [NB-1:0] dec_be;
    logic          dec_err;
    logic          post_load;
    logic          post_valid;
    logic          post_done;
    logic          dir_done;
    logic [WA-1:0] post_addr;
    logic [NB-1:0] post_be;
    logic [DW-1:0] post_data;
    logic          cyc_we;
    logic [WA-1:0] cyc_wa;
    logic [NB-1:0] cyc_be;
    logic [DW-1:0] cyc_wd;
    logic [DW-1:0] rd_q;
    logic [DW-1:0] rd_masked;

    // Control register: enable, 16-bit only, posting
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (cfg_we) ctl_q <= cfg_din;
    end

    assign cfg_q = ctl_q;

    vps_decode #(.NB(NB)) u_dec (
        .off  (bus_addr[OW-1:0]),
        .size (bus_size),
        .d16  (ctl_q[CTL_D16]),
        .be   (dec_be),
        .err  (dec_err)
    );

    // A cycle is taken only when selected and no posted write is outstanding
    always_comb begin
        go        = bus_strb && ctl_q[CTL_EN] && bus_am_ok && !post_valid;
        post_load = (state == ST_IDLE) && go && !dec_err && bus_write && ctl_q[CTL_POST];
    end

    vps_post_buf #(.WA(WA), .DW(DW)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (post_load),
        .ld_addr (bus_addr[AW-1:OW]),
        .ld_be   (dec_be),
        .ld_data (bus_wdata),
        .done    (post_done),
        .valid   (post_valid),
        .addr    (post_addr),
        .be      (post_be),
        .data    (post_data)
    );

    vps_mem_port #(.WA(WA), .DW(DW)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_valid (post_valid),
        .post_addr  (post_addr),
        .post_be    (post_be),
        .post_data  (post_data),
        .dir_req    (state == ST_MEM),
        .dir_we     (cyc_we),
        .dir_addr   (cyc_wa),
        .dir_be     (cyc_be),
        .dir_data   (cyc_wd),
        .post_done  (post_done),
        .dir_done   (dir_done),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack)
    );

    // Zero the lanes a read did not select
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign rd_masked[8*g +: 8] = cyc_be[g] ? mem_rdata[8*g +: 8] : 8'h00;
    end

    // Cycle sequencer: accept, run memory if needed, answer, wait for strobe release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cyc_we <= 1'b0;
            cyc_wa <= '0;
            cyc_be <= '0;
            cyc_wd <= '0;
            rd_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        cyc_we <= bus_write;
                        cyc_wa <= bus_addr[AW-1:OW];
                        cyc_be <= dec_be;
                        cyc_wd <= bus_wdata;
                        if (dec_err)                            state <= ST_BERR;
                        else if (bus_write && ctl_q[CTL_POST]) state <= ST_ACK;
                        else                                    state <= ST_MEM;
                    end
                end
                ST_MEM: begin
                    if (dir_done) begin
                        if (!cyc_we) rd_q <= rd_masked;
                        state <= ST_ACK;
                    end
                end
                ST_ACK, ST_BERR: begin
                    if (!bus_strb) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign bus_dtack = (state == ST_ACK);
    assign bus_berr  = (state == ST_BERR);
    assign bus_rdata = rd_q;

    AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n) !(bus_dtack && bus_berr)) else $error("both answers"); // R11
    AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n) ((bus_dtack || bus_berr) && bus_strb) |=> (bus_dtack || bus_berr)) else $error("answer dropped early"); // R11
    AST_NOT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IDLE && !(ctl_q[CTL_EN] && bus_am_ok)) |=> (state == ST_IDLE)) else $error("responded while unselected"); // R2
    AST_BERR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n) bus_berr |-> !mem_req) else $error("memory touched on bus error"); // R4
    AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n) post_valid |-> (state != ST_MEM)) else $error("direct access while posted write pending"); // R9
    AST_D16_LONG: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IDLE && go && ctl_q[CTL_D16] && bus_size == SZ_LONG) |=> bus_berr) else $error("longword accepted in 16-bit mode"); // R5
endmodule

// File: tb/vme_post_slave_test.sv
module vme_post_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int WA = AW - 2;
    localparam int WORDS = 1 << WA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_din = '0;
    logic [2:0]    cfg_q;
    logic          bus_strb = 1'b0;
    logic          bus_write = 1'b0;
    logic          bus_am_ok = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_dtack;
    logic          bus_berr;
    logic          mem_req;
    logic          mem_we;
    logic [WA-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    vme_post_slave #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_din(cfg_din), .cfg_q(cfg_q),
        .bus_strb(bus_strb), .bus_write(bus_write), .bus_am_ok(bus_am_ok),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_dtack(bus_dtack), .bus_berr(bus_berr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'h1357_9BDF ^ (i * 32'h0101_0307);
    endfunction

    // Memory model with random latency
    logic [31:0]   mem [WORDS];
    int            lat_lo = 0;
    int            lat_hi = 3;
    bit            mbusy = 0;
    int            mcnt = 0;
    int            wr_count = 0;
    int            req_count = 0;
    logic [WA-1:0] last_wa = '0;
    logic [3:0]    last_be = '0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (!rst_n) begin
            mbusy <= 0;
            for (int i = 0; i < WORDS; i++) mem[i] <= pat(i);
        end else if (mbusy) begin
            if (mcnt == 0) begin
                mem_ack <= 1'b1;
                mbusy   <= 0;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
                    wr_count <= wr_count + 1;
                    last_wa  <= mem_addr;
                    last_be  <= mem_be;
                end else begin
                    mem_rdata <= mem[mem_addr];
                end
            end else begin
                mcnt <= mcnt - 1;
            end
        end else if (mem_req && !mem_ack) begin
            mbusy     <= 1;
            mcnt      <= $urandom_range(lat_hi, lat_lo);
            req_count <= req_count + 1;
        end
    end

    // Scoreboard
    typedef struct {
        bit          is_berr;
        bit          is_read;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    exp_t        got;
    bit          prev_resp = 0;
    logic [31:0] shadow [WORDS];
    logic [2:0]  cfg_cur = '0;

    initial begin
        for (int i = 0; i < WORDS; i++) shadow[i] = pat(i);
    end

    // Monitor: pop one expected item per new answer
    always @(negedge clk) begin
        if (rst_n && (bus_dtack || bus_berr) && !prev_resp) begin
            if (sb.size() == 0) begin
                check(0, "R11", "unexpected answer", {31'b0, bus_dtack}, 32'h0);
            end else begin
                got = sb.pop_front();
                check(bus_berr == got.is_berr, got.tag, "answer kind (1=berr)", {31'b0, bus_berr}, {31'b0, got.is_berr});
                if (!got.is_berr && got.is_read)
                    check(bus_rdata == got.data, got.tag, "read data", bus_rdata, got.data);
            end
        end
        prev_resp = bus_dtack || bus_berr;
    end

    function automatic void model(input logic [1:0] sz, input logic [1:0] off, input bit d16,
                                  output bit err, output logic [3:0] be);
        int n;
        n   = 1 << sz;
        err = (sz == 2'd3) || (int'(off) + n > 4) || (d16 && (sz == 2'd2 || (sz == 2'd1 && off[0])));
        be  = 4'(((1 << n) - 1) << off);
    endfunction

    task automatic set_cfg(input logic [2:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_din = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        cfg_cur = v;
    endtask

    // Driver: one bus cycle, expected answer pushed to the scoreboard
    task automatic cycle(input bit we, input logic [7:0] addr, input logic [1:0] sz,
                         input logic [31:0] wd, input string tag, input bit drain_chk);
        bit          err;
        bit          resp;
        logic [3:0]  be;
        logic [31:0] exp_rd;
        exp_t        it;
        int          rq;
        int          wcr;
        logic [WA-1:0] wa;
        model(sz, addr[1:0], cfg_cur[1], err, be);
        wa = addr[7:2];
        @(posedge clk); #1;
        bus_write = we; bus_addr = addr; bus_size = sz; bus_wdata = wd;
        if (!cfg_cur[0] || !bus_am_ok) begin
            rq = req_count;
            bus_strb = 1'b1;
            repeat (12) @(negedge clk);
            check(!bus_dtack && !bus_berr, tag, "answer while unselected", {30'b0, bus_dtack, bus_berr}, 32'h0);
            check(req_count == rq && !mem_req, tag, "memory request while unselected", req_count, rq);
            bus_strb = 1'b0;
            @(negedge clk);
            return;
        end
        exp_rd = '0;
        for (int b = 0; b < 4; b++) if (be[b]) exp_rd[8*b +: 8] = shadow[wa][8*b +: 8];
        it.is_berr = err; it.is_read = !we; it.data = exp_rd; it.tag = tag;
        if (!err && we)
            for (int b = 0; b < 4; b++) if (be[b]) shadow[wa][8*b +: 8] = wd[8*b +: 8];
        sb.push_back(it);
        bus_strb = 1'b1;
        resp = 0;
        for (int k = 0; k < 300 && !resp; k++) begin
            @(negedge clk);
            resp = bus_dtack || bus_berr;
        end
        if (!resp) begin
            check(0, tag, "no answer", 32'h0, 32'h1);
            void'(sb.pop_front());
        end else if (bus_berr) begin
            check(!mem_req, tag, "memory request with bus error", {31'b0, mem_req}, 32'h0);
            rq = req_count;
            repeat (3) @(negedge clk);
            check(req_count == rq && bus_berr, tag, "bus error held, no memory access", req_count, rq);
        end else if (we) begin
            if (cfg_cur[2]) begin
                if (drain_chk) begin
                    wcr = wr_count;
                    for (int k = 0; k < 100 && wr_count == wcr; k++) @(negedge clk);
                    check(wr_count == wcr + 1, "R8", "memory write after posted answer", wr_count, wcr + 1);
                    check(last_wa == wa && last_be == be, "R8", "posted write address/lanes", {22'b0, last_wa, last_be}, {22'b0, wa, be});
                end
            end else begin
                check(!mem_req && last_wa == wa && last_be == be, "R7", "write done before answer",
                      {21'b0, mem_req, last_wa, last_be}, {22'b0, wa, be});
            end
        end
        bus_strb = 1'b0;
        @(negedge clk);
        check(!bus_dtack && !bus_berr, "R11", "answer released after strobe drop", {30'b0, bus_dtack, bus_berr}, 32'h0);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int wcp;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(cfg_q == 3'b000, "R1", "control register after reset", {29'b0, cfg_q}, 32'h0);
        check(!bus_dtack && !bus_berr && !mem_req, "R1", "outputs after reset", {29'b0, bus_dtack, bus_berr, mem_req}, 32'h0);

        // R2: disabled, then unqualified
        cycle(0, 8'h10, 2'd2, 0, "R2", 0);
        set_cfg(3'b001);
        check(cfg_q == 3'b001, "R1", "control register write", {29'b0, cfg_q}, 32'h1);
        bus_am_ok = 1'b0;
        cycle(1, 8'h10, 2'd2, 32'hDEAD_BEEF, "R2", 0);
        bus_am_ok = 1'b1;
        cycle(0, 8'h10, 2'd2, 0, "R2", 0);

        // R3/R7/R12: lane placement with direct writes
        for (int o = 0; o < 4; o++) cycle(1, 8'h20 + 8'(o), 2'd0, 32'hA1B2C3D4 ^ (o * 32'h1111_1111), "R3", 0);
        cycle(0, 8'h20, 2'd2, 0, "R3", 0);
        cycle(1, 8'h26, 2'd1, 32'h5566_0000, "R3", 0);
        cycle(0, 8'h24, 2'd2, 0, "R12", 0);
        cycle(0, 8'h27, 2'd0, 0, "R12", 0);
        cycle(1, 8'h30, 2'd2, 32'hCAFE_F00D, "R7", 0);
        cycle(0, 8'h32, 2'd1, 0, "R12", 0);

        // R6 / R4
        cycle(1, 8'h35, 2'd1, 32'h00AB_CD00, "R6", 0);
        cycle(0, 8'h34, 2'd2, 0, "R6", 0);
        cycle(1, 8'h3A, 2'd2, 32'h1, "R4", 0);
        cycle(0, 8'h3B, 2'd1, 0, "R4", 0);
        cycle(0, 8'h3C, 2'd3, 0, "R4", 0);

        // R5: 16-bit-only mode
        set_cfg(3'b011);
        cycle(0, 8'h34, 2'd2, 0, "R5", 0);
        cycle(1, 8'h35, 2'd1, 32'h0012_3400, "R5", 0);
        cycle(1, 8'h36, 2'd1, 32'h7788_0000, "R5", 0);
        cycle(0, 8'h34, 2'd0, 0, "R5", 0);

        // R8: posted answer ahead of the memory write
        set_cfg(3'b101);
        lat_lo = 4; lat_hi = 6;
        cycle(1, 8'h40, 2'd2, 32'h0BAD_CAFE, "R8", 1);
        cycle(0, 8'h40, 2'd2, 0, "R8", 0);

        // R9/R10: read straight after a slow posted write to the same place
        lat_lo = 10; lat_hi = 10;
        wcp = wr_count;
        cycle(1, 8'h44, 2'd2, 32'h600D_D00D, "R9", 0);
        cycle(0, 8'h44, 2'd2, 0, "R10", 0);
        check(wr_count == wcp + 1, "R9", "posted write drained before read answer", wr_count, wcp + 1);
        cycle(1, 8'h48, 2'd1, 32'h0000_ABCD, "R9", 0);
        cycle(1, 8'h4C, 2'd0, 32'h0000_00EE, "R9", 0);
        cycle(0, 8'h48, 2'd2, 0, "R10", 0);
        cycle(0, 8'h4C, 2'd2, 0, "R10", 0);

        // Mixed traffic across modes and latencies
        lat_lo = 0; lat_hi = 5;
        for (int n = 0; n < 80; n++) begin
            if (n % 10 == 0) set_cfg({1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 1'b1});
            cycle(1'($urandom_range(1, 0)), 8'($urandom_range(255, 0)), 2'($urandom_range(3, 0)),
                  $urandom, "R3", 0);
        end
        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R11", "answers outstanding at end", sb.size(), 0);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule